// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block keeps a short record of how transmitted frames finished, so that the host can learn about failures and requested notifications after the fact. Each time the transmit engine finishes a frame it presents one completion event with four result flags. The flags are: interrupt-on-success requested, jabber, underrun and maximum collisions. The jabber flag is only ever raised by the twisted-pair medium logic. A completion that carries at least one of these flags is stored; a clean completion with no flag set leaves no trace. The host reads the oldest stored record as one status byte. Any write strobe on the status port discards that record, whatever data goes with the write.

Jabber and underrun mean the transmitter must not continue. The same holds for a transmit overrun caused by the host writing too much frame data, which also raises an adapter-failure flag. Each of these conditions latches, and the transmit-permit output stays low until a transmit reset command is given. A transmit reset also empties the record queue and clears the overflow mark. After the reset, the transmitter stays off until a separate transmit-enable command arrives. The synchronous chip reset acts as the global reset.

Top module: `tx_done_stack`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, `status_rd` is 8'h00, and both `tx_allowed` and `adapter_fail` are 0.
- R2: A stored record reads as: bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = overflow mark, and bits 1:0 = 0.
- R3: A completion is stored only if `done_valid` is high, at least one of its four flags is set, and `tx_allowed` is high in that cycle. Otherwise it changes nothing that `status_rd` shows.
- R4: Records leave in arrival order. After a `status_wr` strobe, `status_rd` shows the next older record from the following cycle on.
- R5: With the queue empty, `status_rd` reads 8'h00, and a `status_wr` strobe has no effect.
- R6: The queue holds DEPTH records (default 4). A storable completion that arrives while the queue is full, with no strobe in the same cycle, is dropped and sets the overflow mark. The mark shows as bit 2 of `status_rd` until the next strobe clears it. If a storable completion and a strobe arrive together while the queue is full, the completion is accepted and no overflow is marked.
- R7: A stored completion with jabber or underrun set drives `tx_allowed` low from the next cycle. It stays low through transmit-enable commands until a transmit reset.
- R8: A `host_overrun` pulse sets `adapter_fail` and drives `tx_allowed` low from the next cycle. Neither is released by a transmit-enable command.
- R9: A transmit reset empties the queue, clears the overflow mark, clears the jabber/underrun latch and clears `adapter_fail`. It leaves `tx_allowed` low. It takes priority over a completion, a strobe or an enable command in the same cycle.
- R10: A transmit-enable command with no latched error raises `tx_allowed` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (global reset) |
| done_valid | input | 1 | One frame finished this cycle |
| done_ireq | input | 1 | Frame asked for an interrupt on success |
| done_jabber | input | 1 | Frame ended by jabber (twisted-pair only) |
| done_underrun | input | 1 | Frame ended by transmit underrun |
| done_maxcoll | input | 1 | Frame hit the collision limit |
| host_overrun | input | 1 | Host overfilled the transmit buffer |
| status_wr | input | 1 | Host write to the status port; discards oldest record |
| tx_reset_cmd | input | 1 | Transmit reset command |
| tx_enable_cmd | input | 1 | Transmit enable command |
| status_rd | output | 8 | Oldest record, or 8'h00 when empty |
| tx_allowed | output | 1 | Transmitter may run |
| adapter_fail | output | 1 | Host overrun has been seen since the last transmit reset |

## Verification
A corrupted read or write pointer shows at once as a wrong `status_rd` byte. It may be a repeated, skipped or reordered record after a strobe, visible in the cycle after that strobe. A wrong occupancy count shows either as the overflow mark appearing or missing on the very next storable completion once the queue is near full, or as a nonzero byte after the last record has been drained. A latch that fails to hold or clear shows on `tx_allowed` or `adapter_fail` one cycle after the command or event that should have moved it.

// File: rtl/tx_done_pkg.sv
// Package: shared types and bit positions for the transmit completion queue.
// Assumes: the status byte layout below is decoded by host software, so the
// bit positions are fixed.
package tx_done_pkg;

    // Bit positions inside the host-visible status byte.
    localparam int BIT_DONE = 7;
    localparam int BIT_IREQ = 6;
    localparam int BIT_JAB  = 5;
    localparam int BIT_UND  = 4;
    localparam int BIT_MCOL = 3;
    localparam int BIT_OVF  = 2;

    localparam int STATUS_W = 8;

    // Result flags of one finished frame; this is all the queue stores.
    typedef struct packed {
        logic ireq;
        logic jab;
        logic und;
        logic mcol;
    } txd_flags_t;

    localparam int FLAGS_W = $bits(txd_flags_t);

    // A completion is worth recording when any flag is set.
    function automatic logic worth_storing(input txd_flags_t f);
        return f.ireq | f.jab | f.und | f.mcol;
    endfunction

    // Flags that stop the transmitter until a transmit reset.
    function automatic logic is_fatal(input txd_flags_t f);
        return f.jab | f.und;
    endfunction

endpackage

// File: rtl/tx_done_fifo.sv
// Module: tx_done_fifo
// Holds up to DEPTH completion records, oldest first, plus an overflow mark
// that is raised when a record has to be dropped for lack of room.
// Assumes: push is already qualified by the caller; flush has priority over
// push and pop in the same cycle.
module tx_done_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         nonempty,
    output logic         ovf
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] count_q;
    logic          ovf_q;

    logic do_pop, do_push, drop;

    // Advance a pointer with wrap at DEPTH-1 (DEPTH need not be a power of two).
    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // Decide which of push, pop and drop actually take place this cycle.
    always_comb begin
        do_pop  = pop && (count_q != '0) && !flush;
        do_push = push && !flush && ((count_q != FULL_CNT) || do_pop);
        drop    = push && !flush && (count_q == FULL_CNT) && !do_pop;
    end

    // Record storage; written only when a push is accepted.
    always_ff @(posedge clk) begin
        if (do_push) begin
            slot_q[wr_ptr_q] <= push_data;
        end
    end

    // Pointers, occupancy and overflow mark.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            count_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= step_ptr(wr_ptr_q);
            end
            if (do_pop) begin
                rd_ptr_q <= step_ptr(rd_ptr_q);
            end
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (drop) begin
                ovf_q <= 1'b1;
            end else if (do_pop) begin
                ovf_q <= 1'b0;
            end
        end
    end

    // Present the oldest record.
    always_comb begin
        head_data = slot_q[rd_ptr_q];
        nonempty  = (count_q != '0);
        ovf       = ovf_q;
    end

    AST_DROP_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> ($past(count_q) == FULL_CNT)); // R6

    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && count_q == '0) |=> (count_q == '0)); // R5

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0 && !ovf_q)); // R9

    AST_NEVER_PAST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == FULL_CNT && !pop) |=> (count_q == FULL_CNT || $past(flush))); // R6

endmodule

// File: rtl/tx_done_gate.sv
// Module: tx_done_gate
// Transmit permission: an enable latch plus two error latches (frame halt
// from jabber/underrun, and adapter failure from host overrun). Only a
// transmit reset or the chip reset clears them.
// Assumes: fatal_evt is raised only for completions that were accepted.
module tx_done_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_reset,
    input  logic tx_enable,
    input  logic fatal_evt,
    input  logic host_ovr,
    output logic tx_allowed,
    output logic adapter_fail
);

    logic en_q, halt_q, fail_q;

    // Latch enable and error conditions; transmit reset wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_reset) begin
            en_q   <= 1'b0;
            halt_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (tx_enable) begin
                en_q <= 1'b1;
            end
            if (fatal_evt) begin
                halt_q <= 1'b1;
            end
            if (host_ovr) begin
                fail_q <= 1'b1;
            end
        end
    end

    // Transmitter runs only when enabled and no error is latched.
    always_comb begin
        tx_allowed   = en_q && !halt_q && !fail_q;
        adapter_fail = fail_q;
    end

    AST_RESET_BLOCKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> !tx_allowed); // R9

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !tx_reset) |=> !tx_allowed); // R7

    AST_FAIL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ovr && !tx_reset) |=> (adapter_fail && !tx_allowed)); // R8

    AST_ENABLE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && !tx_reset && !halt_q && !fail_q && !fatal_evt && !host_ovr)
        |=> tx_allowed); // R10

endmodule

// File: rtl/tx_done_format.sv
// Module: tx_done_format
// Builds the host-visible status byte from a stored flag set and the
// overflow mark; an empty queue reads as all zeros.
// Assumes: flags come straight from the queue head.
module tx_done_format
    import tx_done_pkg::*;
(
    input  logic                valid,
    input  txd_flags_t          flags,
    input  logic                ovf,
    output logic [STATUS_W-1:0] status
);

    // Place each flag at its fixed position; low two bits stay zero.
    always_comb begin
        status = '0;
        if (valid) begin
            status[BIT_DONE] = 1'b1;
            status[BIT_IREQ] = flags.ireq;
            status[BIT_JAB]  = flags.jab;
            status[BIT_UND]  = flags.und;
            status[BIT_MCOL] = flags.mcol;
            status[BIT_OVF]  = ovf;
        end
    end

endmodule

// File: rtl/tx_done_stack.sv
// Module: tx_done_stack (top)
// Transmit completion status queue: records flagged completions, lets the
// host read the oldest and discard it with a write strobe, and gates the
// transmitter on fatal errors until a transmit reset.
// Assumes: done_jabber is only raised on the twisted-pair medium; rst_n is
// the global reset and is synchronous.
module tx_done_stack
    import tx_done_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_valid,
    input  logic                done_ireq,
    input  logic                done_jabber,
    input  logic                done_underrun,
    input  logic                done_maxcoll,
    input  logic                host_overrun,
    input  logic                status_wr,
    input  logic                tx_reset_cmd,
    input  logic                tx_enable_cmd,
    output logic [STATUS_W-1:0] status_rd,
    output logic                tx_allowed,
    output logic                adapter_fail
);

    txd_flags_t in_flags, head_flags;
    logic       accept, fatal_evt, head_valid, ovf;

    // Qualify an incoming completion against the flags and the gate.
    always_comb begin
        in_flags  = '{ireq: done_ireq, jab: done_jabber,
                      und: done_underrun, mcol: done_maxcoll};
        accept    = done_valid && tx_allowed && !tx_reset_cmd
                    && worth_storing(in_flags);
        fatal_evt = accept && is_fatal(in_flags);
    end

    tx_done_fifo #(
        .DEPTH (DEPTH),
        .W     (FLAGS_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_reset_cmd),
        .push      (accept),
        .push_data (in_flags),
        .pop       (status_wr),
        .head_data (head_flags),
        .nonempty  (head_valid),
        .ovf       (ovf)
    );

    tx_done_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_reset     (tx_reset_cmd),
        .tx_enable    (tx_enable_cmd),
        .fatal_evt    (fatal_evt),
        .host_ovr     (host_overrun),
        .tx_allowed   (tx_allowed),
        .adapter_fail (adapter_fail)
    );

    tx_done_format u_fmt (
        .valid  (head_valid),
        .flags  (head_flags),
        .ovf    (ovf),
        .status (status_rd)
    );

    AST_IDLE_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_allowed && !status_wr && !tx_reset_cmd) |=> $stable(status_rd)); // R3

    AST_RESET_CLEARS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset_cmd |=> (status_rd == '0)); // R9

endmodule

// File: tb/sim_tx_done_stack.sv
`timescale 1ns/1ps
module sim_tx_done_stack;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_valid = 1'b0, done_ireq = 1'b0, done_jabber = 1'b0;
    logic       done_underrun = 1'b0, done_maxcoll = 1'b0;
    logic       host_overrun = 1'b0, status_wr = 1'b0;
    logic       tx_reset_cmd = 1'b0, tx_enable_cmd = 1'b0;
    logic [7:0] status_rd;
    logic       tx_allowed, adapter_fail;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    tx_done_stack #(.DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .done_valid(done_valid), .done_ireq(done_ireq),
        .done_jabber(done_jabber), .done_underrun(done_underrun),
        .done_maxcoll(done_maxcoll), .host_overrun(host_overrun),
        .status_wr(status_wr), .tx_reset_cmd(tx_reset_cmd),
        .tx_enable_cmd(tx_enable_cmd), .status_rd(status_rd),
        .tx_allowed(tx_allowed), .adapter_fail(adapter_fail)
    );

    // Expected status byte per the bit layout in R2.
    function automatic logic [7:0] rec(input bit i, input bit j, input bit u,
                                       input bit m, input bit o);
        return 8'h80 | (8'(i) << 6) | (8'(j) << 5) | (8'(u) << 4)
               | (8'(m) << 3) | (8'(o) << 2);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic complete(input bit i, input bit j, input bit u, input bit m);
        done_valid = 1'b1; done_ireq = i; done_jabber = j;
        done_underrun = u; done_maxcoll = m;
        step();
        done_valid = 1'b0; done_ireq = 1'b0; done_jabber = 1'b0;
        done_underrun = 1'b0; done_maxcoll = 1'b0;
    endtask

    task automatic pop();
        status_wr = 1'b1; step(); status_wr = 1'b0;
    endtask

    task automatic txrst();
        tx_reset_cmd = 1'b1; step(); tx_reset_cmd = 1'b0;
    endtask

    task automatic txen();
        tx_enable_cmd = 1'b1; step(); tx_enable_cmd = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        // R1: reset state
        chk("R1", "status after reset", status_rd, 8'h00);
        chk("R1", "tx_allowed after reset", {7'b0, tx_allowed}, 8'h00);
        chk("R1", "adapter_fail after reset", {7'b0, adapter_fail}, 8'h00);
        rst_n = 1'b1;
        step();
        chk("R1", "status after release", status_rd, 8'h00);

        // R10: enable raises permission
        txen();
        chk("R10", "tx_allowed after enable", {7'b0, tx_allowed}, 8'h01);

        // R2/R3/R7: sweep every flag combination
        for (int f = 0; f < 16; f++) begin
            bit i = f[3], j = f[2], u = f[1], m = f[0];
            bit store = i | j | u | m;
            bit fatal = j | u;
            txrst();
            txen();
            complete(i, j, u, m);
            chk("R2", $sformatf("record for flags %0h", f), status_rd,
                store ? rec(i, j, u, m, 1'b0) : 8'h00);
            chk("R7", $sformatf("tx_allowed after flags %0h", f),
                {7'b0, tx_allowed}, {7'b0, !fatal});
            txen();
            chk("R7", $sformatf("enable does not release, flags %0h", f),
                {7'b0, tx_allowed}, {7'b0, !fatal});
            pop();
            chk("R4", $sformatf("drained after flags %0h", f), status_rd, 8'h00);
        end

        // R3: completions ignored while disabled
        txrst();
        complete(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R3", "no record while disabled", status_rd, 8'h00);
        txen();

        // R5: strobe on empty queue has no effect
        pop();
        chk("R5", "empty after empty strobe", status_rd, 8'h00);
        complete(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R5", "first push after empty strobe", status_rd, rec(0, 0, 0, 1, 0));
        pop();
        chk("R5", "empty again", status_rd, 8'h00);

        // R4/R6: order, overflow drop and mark
        complete(1, 0, 0, 0);
        complete(0, 0, 0, 1);
        complete(1, 0, 0, 1);
        complete(1, 0, 0, 0);
        chk("R4", "head of full queue", status_rd, rec(1, 0, 0, 0, 0));
        complete(0, 0, 0, 1);
        chk("R6", "overflow mark on head", status_rd, rec(1, 0, 0, 0, 1));
        pop();
        chk("R6", "second record, mark cleared", status_rd, rec(0, 0, 0, 1, 0));
        pop();
        chk("R4", "third record", status_rd, rec(1, 0, 0, 1, 0));
        pop();
        chk("R4", "fourth record", status_rd, rec(1, 0, 0, 0, 0));
        pop();
        chk("R6", "dropped record absent", status_rd, 8'h00);

        // R6: push and strobe together while full
        complete(1, 0, 0, 0);
        complete(0, 0, 0, 1);
        complete(1, 0, 0, 1);
        complete(0, 0, 0, 1);
        status_wr = 1'b1;
        complete(1, 0, 0, 1);
        status_wr = 1'b0;
        chk("R6", "head after push+strobe on full", status_rd, rec(0, 0, 0, 1, 0));
        pop();
        chk("R6", "order kept 2", status_rd, rec(1, 0, 0, 1, 0));
        pop();
        chk("R6", "order kept 3", status_rd, rec(0, 0, 0, 1, 0));
        pop();
        chk("R6", "accepted record arrived", status_rd, rec(1, 0, 0, 1, 0));
        pop();
        chk("R6", "empty after drain", status_rd, 8'h00);

        // R8: host overrun
        host_overrun = 1'b1; step(); host_overrun = 1'b0;
        chk("R8", "adapter_fail set", {7'b0, adapter_fail}, 8'h01);
        chk("R8", "tx_allowed dropped", {7'b0, tx_allowed}, 8'h00);
        txen();
        chk("R8", "enable does not release", {7'b0, tx_allowed}, 8'h00);
        chk("R8", "adapter_fail holds", {7'b0, adapter_fail}, 8'h01);
        txrst();
        chk("R9", "adapter_fail cleared", {7'b0, adapter_fail}, 8'h00);
        chk("R9", "still disabled after reset", {7'b0, tx_allowed}, 8'h00);
        txen();
        chk("R10", "enabled after reset+enable", {7'b0, tx_allowed}, 8'h01);

        // R9: reset priority and full clear
        for (int k = 0; k < 5; k++) complete(1, 0, 0, 0);
        chk("R6", "overflow before reset", status_rd, rec(1, 0, 0, 0, 1));
        tx_reset_cmd = 1'b1; tx_enable_cmd = 1'b1; status_wr = 1'b1;
        complete(0, 0, 0, 1);
        tx_reset_cmd = 1'b0; tx_enable_cmd = 1'b0; status_wr = 1'b0;
        chk("R9", "queue empty after reset", status_rd, 8'h00);
        chk("R9", "reset beats enable", {7'b0, tx_allowed}, 8'h00);
        txen();
        complete(1, 0, 0, 0);
        chk("R9", "overflow mark gone", status_rd, rec(1, 0, 0, 0, 0));
        pop();

        // R7: latch persists across idle cycles until reset
        complete(0, 0, 1, 0);
        repeat (5) step();
        chk("R7", "underrun latch persists", {7'b0, tx_allowed}, 8'h00);
        txrst();
        txen();
        chk("R7", "released by reset", {7'b0, tx_allowed}, 8'h01);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule